// File: doc/BRIEF.md
# Radix Translation Root Locator

This block finds where the radix page tree for one virtual address begins. A start pulse hands it the address, the hypervisor and problem-state bits of the machine state, the partition table control word and the partition and process ID registers. The block first settles which partition and which process the access belongs to. It then reads one word from the partition table to learn where the process table lives, and reads one word from the process table. From that word it extracts the root directory base, the root directory size and the radix tree size.

Memory is reached through a single 64-bit read port. The block raises `mem_req` for one cycle with an address and waits for `mem_rvalid` with the data. Only one read is ever outstanding. If the address falls in a quadrant that the current mode may not use, the block reports a fault without touching memory. The walk down the tree that follows is done elsewhere.

Top module: `radix_root_finder`

## Requirements
- R1: After reset `done`, `fault` and `mem_req` are low, and `root_base`, `root_size` and `tree_size` are zero.
- R2: The first read address is `{4'b0, ptcr[59:12], 12'b0} + eff_lpid*16 + 8`. This is the second doubleword of the 16-byte partition entry.
- R3: The effective partition ID is 0 when `hv` is 1, and `lpid_reg` otherwise.
- R4: The second read address is `{4'b0, d1[59:12], 12'b0} + eff_pid*16`, where `d1` is the data returned by the first read.
- R5: With `hv`=1 and `pr`=0, quadrant `vaddr[63:62]` 2'b11 or 2'b10 selects process ID 0, and 2'b00 or 2'b01 selects `pid_reg`.
- R6: In every other mode, quadrant 2'b11 selects process ID 0 and 2'b00 selects `pid_reg`. Quadrants 2'b01 and 2'b10 raise a one-cycle `fault` in the cycle after start, with no memory read and no `done`.
- R7: From the process word `d2`: `root_base = {4'b0, d2[59:8], 8'b0}`, `root_size = d2[4:0]` and `tree_size = {d2[62:61], d2[7:5]}`.
- R8: A successful lookup issues exactly two reads, in order. Each `mem_req` lasts one cycle. The second read starts only after the first `mem_rvalid`. `mem_addr` holds steady while a read is outstanding.
- R9: `done` is a one-cycle pulse in the cycle after the second `mem_rvalid`. The result outputs hold their values until the next lookup completes.
- R10: A start pulse that arrives while a lookup is in progress is ignored. The lookup in progress keeps its captured inputs and produces no extra read and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (accepted when idle) |
| vaddr | input | 64 | Virtual address; bits 63:62 are the quadrant |
| hv | input | 1 | Hypervisor state bit |
| pr | input | 1 | Problem (user) state bit |
| ptcr | input | 64 | Partition table control word, base in bits 59:12 |
| lpid_reg | input | LPID_W | Partition ID register |
| pid_reg | input | PID_W | Process ID register |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| root_base | output | 64 | Root directory base address |
| root_size | output | 5 | Root directory size field |
| tree_size | output | 5 | Radix tree size field |
| done | output | 1 | One-cycle pulse, result valid |
| fault | output | 1 | One-cycle pulse, illegal quadrant |

## Verification
Two functions can fall in the same cycle: accepting a new start and finishing or waiting on a read already in flight. The bench provokes this with a second start pulse while a read is outstanding. That second pulse carries an illegal quadrant and different register values. The overlap is judged at the memory port and the outputs. The bench checks that exactly two reads appear at the addresses of the first request, that no fault pulse shows up, and that the results match the first request's table words.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int DW        = 64;
  localparam int BASE_MSB  = 59;
  localparam int TBL_SH    = 12;
  localparam int DIR_SH    = 8;
  localparam int ENT_SH    = 4;
  localparam int SECOND_DW = 8;
  localparam int SZ_W      = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PART = 2'd1,
    ST_PROC = 2'd2
  } rrf_state_e;
endpackage

// File: rtl/rrf_id_sel.sv
module rrf_id_sel #(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic              hv,
  input  logic              pr,
  input  logic [1:0]        quad,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic [LPID_W-1:0] eff_lpid,
  output logic [PID_W-1:0]  eff_pid,
  output logic              illegal
);
  always_comb begin
    eff_lpid = hv ? '0 : lpid_reg;
    eff_pid  = pid_reg;
    illegal  = 1'b0;
    if (quad == 2'b11) begin
      eff_pid = '0;
    end else if (hv && !pr) begin
      if (quad == 2'b10) eff_pid = '0;
    end else if (quad != 2'b00) begin
      illegal = 1'b1;
      eff_pid = '0;
    end
  end
endmodule

// File: rtl/rrf_seq.sv
module rrf_seq
  import rrf_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              illegal,
  input  logic [LPID_W-1:0] eff_lpid,
  input  logic [PID_W-1:0]  eff_pid,
  input  logic [DW-1:0]     ptcr,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_req,
  output logic [DW-1:0]     mem_addr,
  output logic              load_root,
  output logic              done,
  output logic              fault
);
  rrf_state_e           state;
  logic [PID_W-1:0]     pid_q;
  logic [DW-1:0]        part_addr;
  logic [DW-1:0]        proc_addr;
  logic                 unused_bits;

  assign part_addr = (DW'(ptcr[BASE_MSB:TBL_SH]) << TBL_SH)
                   + (DW'(eff_lpid) << ENT_SH) + DW'(SECOND_DW);
  assign proc_addr = (DW'(mem_rdata[BASE_MSB:TBL_SH]) << TBL_SH)
                   + (DW'(pid_q) << ENT_SH);
  assign unused_bits = ^{ptcr[DW-1:BASE_MSB+1], ptcr[TBL_SH-1:0],
                         mem_rdata[DW-1:BASE_MSB+1], mem_rdata[TBL_SH-1:0]};

  assign load_root = (state == ST_PROC) && mem_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      pid_q    <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (illegal) begin
              fault <= 1'b1;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= part_addr;
              pid_q    <= eff_pid;
              state    <= ST_PART;
            end
          end
        end
        ST_PART: begin
          if (mem_rvalid) begin
            mem_req  <= 1'b1;
            mem_addr <= proc_addr;
            state    <= ST_PROC;
          end
        end
        ST_PROC: begin
          if (mem_rvalid) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrf_root_decode.sv
module rrf_root_decode
  import rrf_pkg::*;
(
  input  logic [DW-1:0]   entry,
  output logic [DW-1:0]   base,
  output logic [SZ_W-1:0] dir_size,
  output logic [SZ_W-1:0] rts
);
  logic unused_bits;
  assign base        = DW'(entry[BASE_MSB:DIR_SH]) << DIR_SH;
  assign dir_size    = entry[SZ_W-1:0];
  assign rts         = {entry[62:61], entry[7:5]};
  assign unused_bits = ^{entry[63], entry[60]};
endmodule

// File: rtl/radix_root_finder.sv
module radix_root_finder
  import rrf_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [63:0]       vaddr,
  input  logic              hv,
  input  logic              pr,
  input  logic [63:0]       ptcr,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic [63:0]       root_base,
  output logic [4:0]        root_size,
  output logic [4:0]        tree_size,
  output logic              done,
  output logic              fault
);
  logic [LPID_W-1:0] eff_lpid;
  logic [PID_W-1:0]  eff_pid;
  logic              illegal;
  logic              load_root;
  logic [DW-1:0]     dec_base;
  logic [SZ_W-1:0]   dec_size;
  logic [SZ_W-1:0]   dec_rts;
  logic              unused_va;

  assign unused_va = ^vaddr[61:0];

  rrf_id_sel #(.LPID_W(LPID_W), .PID_W(PID_W)) u_ids (
    .hv(hv), .pr(pr), .quad(vaddr[63:62]),
    .lpid_reg(lpid_reg), .pid_reg(pid_reg),
    .eff_lpid(eff_lpid), .eff_pid(eff_pid), .illegal(illegal)
  );

  rrf_seq #(.LPID_W(LPID_W), .PID_W(PID_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .illegal(illegal),
    .eff_lpid(eff_lpid), .eff_pid(eff_pid), .ptcr(ptcr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .load_root(load_root),
    .done(done), .fault(fault)
  );

  rrf_root_decode u_dec (
    .entry(mem_rdata), .base(dec_base), .dir_size(dec_size), .rts(dec_rts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      root_base <= '0;
      root_size <= '0;
      tree_size <= '0;
    end else if (load_root) begin
      root_base <= dec_base;
      root_size <= dec_size;
      tree_size <= dec_rts;
    end
  end
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        mem_rvalid,
  input logic        done,
  input logic        fault
);
  logic       outstanding;
  logic [1:0] req_cnt;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (mem_req) outstanding <= 1'b1;
    else if (mem_rvalid) outstanding <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || done || fault) req_cnt <= '0;
    else if (mem_req && req_cnt != 2'd3) req_cnt <= req_cnt + 2'd1;
  end

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !outstanding);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outstanding && !mem_rvalid && !mem_req) |=> $stable(mem_addr));
  // R8
  two_reads_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (req_cnt < 2'd2));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rvalid));
  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($past(start) && !mem_req && !done));
endmodule

bind radix_root_finder rrf_checker u_rrf_chk (
  .clk(clk), .rst(rst), .start(start), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .done(done), .fault(fault)
);

// File: tb/sim_radix_root_finder.sv
`timescale 1ns/1ps
module sim_radix_root_finder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] vaddr = '0;
  logic        hv = 1'b0;
  logic        pr = 1'b0;
  logic [63:0] ptcr = '0;
  logic [11:0] lpid_reg = '0;
  logic [19:0] pid_reg = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [63:0] root_base;
  logic [4:0]  root_size;
  logic [4:0]  tree_size;
  logic        done;
  logic        fault;

  int checks = 0;
  int fails  = 0;

  // memory model state
  logic [63:0] pate_word, prte_word, exp_a1, exp_a2;
  int          lat = 0;
  int          rd_count = 0;
  logic [63:0] rd_addr [4];
  logic        pending = 1'b0;
  logic [63:0] pend_addr = '0;
  int          wait_ctr = 0;

  always #4 clk = ~clk;

  radix_root_finder u0 (
    .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .hv(hv), .pr(pr),
    .ptcr(ptcr), .lpid_reg(lpid_reg), .pid_reg(pid_reg),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .root_base(root_base), .root_size(root_size),
    .tree_size(tree_size), .done(done), .fault(fault)
  );

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pending) begin
      if (wait_ctr == 0) begin
        mem_rvalid = 1'b1;
        if (pend_addr == exp_a1) mem_rdata = pate_word;
        else if (pend_addr == exp_a2) mem_rdata = prte_word;
        else mem_rdata = 64'h0BAD_0BAD_0BAD_0BAD;
        pending = 1'b0;
      end else begin
        wait_ctr = wait_ctr - 1;
      end
    end
    if (mem_req) begin
      pending   = 1'b1;
      pend_addr = mem_addr;
      wait_ctr  = lat;
      if (rd_count < 4) rd_addr[rd_count] = mem_addr;
      rd_count  = rd_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] tbl_base(input logic [63:0] w);
    return {4'b0, w[59:12], 12'b0};
  endfunction

  // returns 1 when the quadrant is illegal for the mode
  function automatic bit pick_pid(input bit h, input bit p, input logic [1:0] q,
                                  input logic [19:0] preg, output logic [19:0] pid);
    pid = preg;
    if (h && !p) begin
      if (q[1]) pid = '0;
      return 1'b0;
    end
    if (q == 2'b11) begin pid = '0; return 1'b0; end
    if (q == 2'b00) return 1'b0;
    pid = '0;
    return 1'b1;
  endfunction

  task automatic run_walk(input logic [63:0] va, input bit h, input bit p,
                          input logic [63:0] pt, input logic [11:0] lp,
                          input logic [19:0] pd, input logic [63:0] d1,
                          input logic [63:0] d2, input int latency,
                          input bit poke, input string tag);
    logic [19:0] epid;
    logic [11:0] elpid;
    bit          bad;
    bit          got_done = 1'b0;
    bit          got_fault = 1'b0;
    logic [63:0] old_base = root_base;
    bad   = pick_pid(h, p, va[63:62], pd, epid);
    elpid = h ? 12'd0 : lp;
    pate_word = d1;
    prte_word = d2;
    exp_a1 = tbl_base(pt) + ({52'd0, elpid} << 4) + 64'd8;
    exp_a2 = tbl_base(d1) + ({44'd0, epid} << 4);
    lat = latency;
    rd_count = 0;
    @(negedge clk);
    vaddr = va; hv = h; pr = p; ptcr = pt; lpid_reg = lp; pid_reg = pd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      vaddr = 64'h4000_0000_0000_0000; hv = 1'b0; pr = 1'b1;
      ptcr = 64'h0000_0000_00F0_0000; lpid_reg = 12'h7FF; pid_reg = 20'hFFFFF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 80; i++) begin
      if (done || fault) begin
        got_done = done;
        got_fault = fault;
        break;
      end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    if (bad) begin
      // R6: illegal quadrant -> fault, no read
      chk(got_fault, {"R6 fault raised ", tag}, {63'd0, got_fault}, 64'd1);
      chk(!got_done, {"R6 no done ", tag}, {63'd0, got_done}, 64'd0);
      chk(rd_count == 0, {"R6 no reads ", tag}, 64'(rd_count), 64'd0);
      chk(root_base == old_base, {"R9 outputs held ", tag}, root_base, old_base);
    end else begin
      chk(got_done && !got_fault, {"R9 done seen ", tag},
          {62'd0, got_fault, got_done}, 64'd1);
      chk(rd_count == 2, {"R8 read count ", tag}, 64'(rd_count), 64'd2);
      chk(rd_addr[0] == exp_a1, {"R2/R3 first address ", tag}, rd_addr[0], exp_a1);
      chk(rd_addr[1] == exp_a2, {"R4/R5 second address ", tag}, rd_addr[1], exp_a2);
      chk(root_base == {4'b0, d2[59:8], 8'b0}, {"R7 root base ", tag},
          root_base, {4'b0, d2[59:8], 8'b0});
      chk(root_size == d2[4:0], {"R7 root size ", tag},
          64'(root_size), 64'(d2[4:0]));
      chk(tree_size == {d2[62:61], d2[7:5]}, {"R7 tree size ", tag},
          64'(tree_size), 64'({d2[62:61], d2[7:5]}));
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!done && !fault && !mem_req, "R1 control low",
        {61'd0, done, fault, mem_req}, 64'd0);
    chk(root_base == 0, "R1 root base zero", root_base, 64'd0);
    chk(root_size == 0 && tree_size == 0, "R1 sizes zero",
        {54'd0, root_size, tree_size}, 64'd0);
  endtask

  task automatic t_hv_user;   // R3 R5/R6 legal quadrant 00 in hv user mode
    run_walk(64'h0000_0000_0000_1000, 1'b1, 1'b1, 64'h0000_0000_0001_0004,
             12'd5, 20'd1, 64'h0000_0000_0100_000B, 64'h4000_0000_0003_00AD,
             0, 1'b0, "hv-user q00");
  endtask

  task automatic t_guest;     // R3 guest uses lpid, q11 -> pid 0
    run_walk(64'hC000_0108_0000_3000, 1'b0, 1'b0, 64'h0000_0000_0002_0003,
             12'd3, 20'd7, 64'h0000_0000_0200_0005, 64'hC000_0000_0045_60E9,
             3, 1'b0, "guest q11");
  endtask

  task automatic t_hv_kernel; // R5 quadrants 10 and 01
    run_walk(64'h8000_0000_0000_0000, 1'b1, 1'b0, 64'h0000_0000_0003_0000,
             12'd9, 20'd12, 64'h0000_0000_0004_0000, 64'h2000_0000_0012_3456,
             1, 1'b0, "hv-kernel q10");
    run_walk(64'h4000_0000_0000_0000, 1'b1, 1'b0, 64'h0000_0000_0003_0000,
             12'd9, 20'd12, 64'h0FFF_FFFF_FFFF_F000, 64'h6FFF_FFFF_FFFF_FFFF,
             2, 1'b0, "hv-kernel q01");
  endtask

  task automatic t_illegal;   // R6 quadrants 01 and 10 outside hv kernel
    run_walk(64'h4000_0000_0000_0000, 1'b0, 1'b1, 64'h0000_0000_0005_0000,
             12'd1, 20'd2, 64'h0, 64'h0, 0, 1'b0, "user q01");
    run_walk(64'h8000_0000_0000_0000, 1'b1, 1'b1, 64'h0000_0000_0005_0000,
             12'd1, 20'd2, 64'h0, 64'h0, 0, 1'b0, "hv-user q10");
  endtask

  task automatic t_busy_start; // R10 start while a read is outstanding
    run_walk(64'h0000_0000_0000_2000, 1'b0, 1'b1, 64'h0000_0000_0006_0000,
             12'd4, 20'd3, 64'h0000_0000_0007_0000, 64'h0000_0000_0088_0025,
             6, 1'b1, "R10 busy start");
  endtask

  initial begin
    t_reset();
    t_hv_user();
    t_guest();
    t_hv_kernel();
    t_illegal();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule